// File: doc/BRIEF.md
# Hysteretic Over-Temperature Alarm

This block watches the stream of finished temperature conversions and raises an alarm when a reading climbs above a programmable upper limit. The alarm holds until a later reading drops under a separate lower limit, so the gap between the two limits acts as hysteresis. Software can also clear the alarm with a control bit. If the temperature is still too high, the alarm comes back at the next conversion.

The alarm level can be set to active-high or active-low, and it can be forced to its inactive level. A status bit mirrors the alarm level. Two sticky history flags record whether any reading went above the upper limit or below the lower one. Each flag clears only when two things are true: a status read has happened, and the condition is no longer present. The block produces a logical level only; the pad driver lies outside it.

Top module: `ot_alarm`

## Requirements
- R1: On a conversion strobe, the alarm becomes active when the result, with its low five bits masked, is strictly greater than the upper limit. Equality does not trip it. The comparison is two's-complement signed.
- R2: On a conversion strobe, an active alarm becomes inactive when the masked result is strictly below the lower limit. A result between the limits, or equal to the lower limit, leaves the alarm state unchanged.
- R3: A control write with bit 13 set clears the alarm. A later conversion above the upper limit sets it again. Bit 13 always reads back as 0 in the status word.
- R4: A control write with bit 13 clear never clears the alarm. This includes writes that set bit 15 or bit 14 (the shutdown and one-shot requests).
- R5: Control bit 6 selects the polarity and resets to 0. When it is 1, `alarm_pin_o` is 1 while the alarm is active; when it is 0, the pin is 0 while the alarm is active. The inactive level is always the opposite of the active level.
- R6: Control bit 7 set to 1 forces `alarm_pin_o` to its inactive level. The internal alarm state is kept, so clearing bit 7 shows the alarm again.
- R7: `alarm_stat_o` equals the level of `alarm_pin_o`. The status word carries the following bits, and every other bit is 0:
  - bit 11: alarm status
  - bit 10: high flag
  - bit 9: low flag
  - bit 7: disable
  - bit 6: polarity
- R8: The high flag sets on a conversion above the upper limit. A status read clears it only if the most recent conversion was not above that limit. Otherwise it holds.
- R9: The low flag sets on a conversion below the lower limit. A status read clears it only if the most recent conversion was not below that limit. Otherwise it holds.
- R10: Each limit register stores bits 15:5 of the written value, and bits 4:0 read as 0. After reset the upper limit reads 4880h and the lower limit reads 4600h.
- R11: A limit write does not change the alarm or the flags; the new limit is used from the next conversion strobe on. A result of 489Fh against an upper limit of 4880h does not trip the alarm, because masking makes it equal to the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| result_i | input | 16 | Signed conversion result |
| conv_done_i | input | 1 | One-cycle strobe: `result_i` is a new result |
| hi_wr_i | input | 1 | Write strobe for the upper limit |
| lo_wr_i | input | 1 | Write strobe for the lower limit |
| lim_wdata_i | input | 16 | Limit write data |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word (bit 13 clear, bit 7 disable, bit 6 polarity) |
| stat_rd_i | input | 1 | Status word read strobe |
| alarm_pin_o | output | 1 | Logical alarm pin level |
| alarm_stat_o | output | 1 | Alarm status bit |
| hi_flag_o | output | 1 | Sticky above-upper-limit flag |
| lo_flag_o | output | 1 | Sticky below-lower-limit flag |
| hi_lim_o | output | 16 | Upper limit readback |
| lo_lim_o | output | 16 | Lower limit readback |
| stat_word_o | output | 16 | Status word readback |

## Verification
The bench probes the boundaries of the comparisons:
- **Exact equality with either limit.** A design using >= would trip at equality, and a design using <= would release at equality.
- **A result whose only excess lies in the masked low bits.** A design that skipped the mask would trip on 489Fh.
- **A positive result against a negative limit.** An unsigned comparator would get this one wrong.

It also checks the software clear and its re-arm. A clear that latched would never re-assert; a clear decoded from the wrong bit would drop the alarm on a shutdown request.

Finally, it reads the flags while their condition is still present, which catches a flag that clears on any read. It also toggles polarity and disable while the alarm is active. An inverted polarity sense, or a disable that destroys the alarm state, both show up at the pin.

// File: rtl/ot_alarm_pkg.sv
// Package: shared widths and bit positions of the over-temperature alarm.
// Assumes a 16-bit two's-complement temperature word.
package ot_alarm_pkg;
    localparam int DATA_W   = 16;
    localparam int LIM_LSB  = 5;   // limit granularity: bits below are dropped
    localparam int CLR_BIT  = 13;  // control: clear alarm (self-clearing)
    localparam int STAT_BIT = 11;  // status: alarm level
    localparam int HIF_BIT  = 10;  // status: high history flag
    localparam int LOF_BIT  = 9;   // status: low history flag
    localparam int DIS_BIT  = 7;   // control: force pin inactive
    localparam int POL_BIT  = 6;   // control: 1 = active-high pin
endpackage

// File: rtl/ot_limit_reg.sv
// Limit register: keeps only the bits at and above LIM_LSB of a write.
// The lower bits always read as zero. Assumes a one-cycle write strobe.
module ot_limit_reg #(
    parameter int              DATA_W  = 16,
    parameter int              LIM_LSB = 5,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] lim_o
);
    localparam int KEEP_W = DATA_W - LIM_LSB;

    logic [KEEP_W-1:0] keep_q;

    // Capture the stored upper bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            keep_q <= RST_VAL[DATA_W-1:LIM_LSB];
        else if (wr_i)
            keep_q <= wdata_i[DATA_W-1:LIM_LSB];
    end

    // Rebuild the full-width value with zero low bits.
    always_comb lim_o = {keep_q, {LIM_LSB{1'b0}}};
endmodule

// File: rtl/ot_window_cmp.sv
// Window comparator: masks the low LIM_LSB bits of the result, then
// compares it signed against both limits. Purely combinational.
module ot_window_cmp #(
    parameter int DATA_W  = 16,
    parameter int LIM_LSB = 5
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic [DATA_W-1:0] hi_lim_i,
    input  logic [DATA_W-1:0] lo_lim_i,
    output logic              above_o,
    output logic              below_o
);
    logic signed [DATA_W-1:0] masked;

    // Drop the bits finer than the limit step, then compare signed.
    always_comb begin
        masked  = signed'({result_i[DATA_W-1:LIM_LSB], {LIM_LSB{1'b0}}});
        above_o = masked > signed'(hi_lim_i);
        below_o = masked < signed'(lo_lim_i);
    end
endmodule

// File: rtl/ot_hist_flag.sv
// Sticky history flag. It sets on a conversion that meets its condition.
// It clears on a status read only when the latest conversion did not meet
// the condition. A set in the same cycle as a read takes priority.
module ot_hist_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_i,
    input  logic cond_i,
    input  logic rd_i,
    output logic flag_o
);
    logic cond_q;
    logic cond_now;

    // The condition seen by the most recent conversion, this cycle included.
    always_comb cond_now = conv_i ? cond_i : cond_q;

    // Track the condition and update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            if (conv_i)
                cond_q <= cond_i;
            if (conv_i && cond_i)
                flag_o <= 1'b1;
            else if (rd_i && !cond_now)
                flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ot_alarm.sv
// Hysteretic over-temperature alarm.
// - Sets on a result above the upper limit.
// - Releases on a result below the lower limit.
// - Can be cleared by software; the next conversion re-arms it.
// - Output has selectable polarity and can be forced inactive.
// Assumes one-cycle strobes from the converter and the register bus.
module ot_alarm #(
    parameter int                DATA_W = ot_alarm_pkg::DATA_W,
    parameter int                LIM_LSB = ot_alarm_pkg::LIM_LSB,
    parameter logic [DATA_W-1:0] HI_RST = 16'h4880,
    parameter logic [DATA_W-1:0] LO_RST = 16'h4600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result_i,
    input  logic              conv_done_i,
    input  logic              hi_wr_i,
    input  logic              lo_wr_i,
    input  logic [DATA_W-1:0] lim_wdata_i,
    input  logic              ctrl_wr_i,
    input  logic [DATA_W-1:0] ctrl_wdata_i,
    input  logic              stat_rd_i,
    output logic              alarm_pin_o,
    output logic              alarm_stat_o,
    output logic              hi_flag_o,
    output logic              lo_flag_o,
    output logic [DATA_W-1:0] hi_lim_o,
    output logic [DATA_W-1:0] lo_lim_o,
    output logic [DATA_W-1:0] stat_word_o
);
    import ot_alarm_pkg::*;

    localparam int NLIM = 2;  // index 0 = upper limit, 1 = lower limit

    logic [NLIM-1:0]             lim_wr;
    logic [NLIM-1:0][DATA_W-1:0] lim_q;
    logic [NLIM-1:0]             cond;
    logic [NLIM-1:0]             flag;
    logic                        above;
    logic                        below;
    logic                        trip_q;
    logic                        ctrl_pol_q;
    logic                        ctrl_dis_q;

    // Map the write strobes onto the per-limit array.
    always_comb lim_wr = {lo_wr_i, hi_wr_i};

    // One limit register and one history flag per limit.
    for (genvar g = 0; g < NLIM; g++) begin : g_lim
        ot_limit_reg #(
            .DATA_W (DATA_W),
            .LIM_LSB(LIM_LSB),
            .RST_VAL(g == 0 ? HI_RST : LO_RST)
        ) u_lim (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (lim_wr[g]),
            .wdata_i(lim_wdata_i),
            .lim_o  (lim_q[g])
        );

        ot_hist_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .conv_i(conv_done_i),
            .cond_i(cond[g]),
            .rd_i  (stat_rd_i),
            .flag_o(flag[g])
        );
    end

    ot_window_cmp #(
        .DATA_W (DATA_W),
        .LIM_LSB(LIM_LSB)
    ) u_cmp (
        .result_i(result_i),
        .hi_lim_i(lim_q[0]),
        .lo_lim_i(lim_q[1]),
        .above_o (above),
        .below_o (below)
    );

    // Gather the per-limit conditions into the flag array.
    always_comb cond = {below, above};

    // Control bits: polarity and disable. The clear bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_pol_q <= 1'b0;
            ctrl_dis_q <= 1'b0;
        end else if (ctrl_wr_i) begin
            ctrl_pol_q <= ctrl_wdata_i[POL_BIT];
            ctrl_dis_q <= ctrl_wdata_i[DIS_BIT];
        end
    end

    // Alarm state: a conversion result overrides a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trip_q <= 1'b0;
        else if (conv_done_i && above)
            trip_q <= 1'b1;
        else if (conv_done_i && below)
            trip_q <= 1'b0;
        else if (ctrl_wr_i && ctrl_wdata_i[CLR_BIT])
            trip_q <= 1'b0;
    end

    // Pin level, status bit, flags, limit readback and status word.
    always_comb begin
        alarm_pin_o           = (trip_q && !ctrl_dis_q) ? ctrl_pol_q : !ctrl_pol_q;
        alarm_stat_o          = alarm_pin_o;
        hi_flag_o             = flag[0];
        lo_flag_o             = flag[1];
        hi_lim_o              = lim_q[0];
        lo_lim_o              = lim_q[1];
        stat_word_o           = '0;
        stat_word_o[STAT_BIT] = alarm_pin_o;
        stat_word_o[HIF_BIT]  = flag[0];
        stat_word_o[LOF_BIT]  = flag[1];
        stat_word_o[DIS_BIT]  = ctrl_dis_q;
        stat_word_o[POL_BIT]  = ctrl_pol_q;
    end
endmodule

// File: rtl/ot_alarm_chk.sv
// Checker for ot_alarm. It recomputes the window conditions from the ports
// and checks how the pin, the flags and the limits respond over time.
module ot_alarm_chk #(
    parameter int DATA_W  = 16,
    parameter int LIM_LSB = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] result_i,
    input logic              conv_done_i,
    input logic              hi_wr_i,
    input logic              lo_wr_i,
    input logic [DATA_W-1:0] lim_wdata_i,
    input logic              ctrl_wr_i,
    input logic [DATA_W-1:0] ctrl_wdata_i,
    input logic              stat_rd_i,
    input logic              alarm_pin_o,
    input logic              hi_flag_o,
    input logic              lo_flag_o,
    input logic [DATA_W-1:0] hi_lim_o,
    input logic [DATA_W-1:0] lo_lim_o,
    input logic              ctrl_pol_q,
    input logic              ctrl_dis_q
);
    logic signed [DATA_W-1:0] m;
    logic                     over;
    logic                     under;

    always_comb begin
        m     = signed'(result_i & ~DATA_W'((1 << LIM_LSB) - 1));
        over  = m > signed'(hi_lim_o);
        under = m < signed'(lo_lim_o);
    end

    assert_trip_above_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i && over && !ctrl_wr_i |=> alarm_pin_o == (ctrl_dis_q ? !ctrl_pol_q : ctrl_pol_q));

    assert_release_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i && under && !ctrl_wr_i |=> alarm_pin_o == !ctrl_pol_q);

    assert_sw_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i && ctrl_wdata_i[13] && !conv_done_i |=> alarm_pin_o == !ctrl_pol_q);

    assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done_i && !ctrl_wr_i |=> $stable(alarm_pin_o));

    assert_hi_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i && over |=> hi_flag_o);

    assert_hi_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_flag_o && !stat_rd_i |=> hi_flag_o);

    assert_lo_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i && under |=> lo_flag_o);

    assert_lo_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_flag_o && !stat_rd_i |=> lo_flag_o);

    assert_hi_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_i |=> hi_lim_o[DATA_W-1:LIM_LSB] == $past(lim_wdata_i[DATA_W-1:LIM_LSB]));

    assert_lo_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_i |=> lo_lim_o[DATA_W-1:LIM_LSB] == $past(lim_wdata_i[DATA_W-1:LIM_LSB]));
endmodule

bind ot_alarm ot_alarm_chk #(.DATA_W(DATA_W), .LIM_LSB(LIM_LSB)) u_ot_alarm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .result_i    (result_i),
    .conv_done_i (conv_done_i),
    .hi_wr_i     (hi_wr_i),
    .lo_wr_i     (lo_wr_i),
    .lim_wdata_i (lim_wdata_i),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_wdata_i(ctrl_wdata_i),
    .stat_rd_i   (stat_rd_i),
    .alarm_pin_o (alarm_pin_o),
    .hi_flag_o   (hi_flag_o),
    .lo_flag_o   (lo_flag_o),
    .hi_lim_o    (hi_lim_o),
    .lo_lim_o    (lo_lim_o),
    .ctrl_pol_q  (ctrl_pol_q),
    .ctrl_dis_q  (ctrl_dis_q)
);

// File: tb/test_ot_alarm.sv
// Directed bench for ot_alarm: one task per scenario, each checking itself.
module test_ot_alarm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] result_i = '0;
    logic        conv_done_i = 1'b0;
    logic        hi_wr_i = 1'b0;
    logic        lo_wr_i = 1'b0;
    logic [15:0] lim_wdata_i = '0;
    logic        ctrl_wr_i = 1'b0;
    logic [15:0] ctrl_wdata_i = '0;
    logic        stat_rd_i = 1'b0;
    logic        alarm_pin_o;
    logic        alarm_stat_o;
    logic        hi_flag_o;
    logic        lo_flag_o;
    logic [15:0] hi_lim_o;
    logic [15:0] lo_lim_o;
    logic [15:0] stat_word_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ot_alarm i_ot_alarm (
        .clk(clk), .rst_n(rst_n), .result_i(result_i), .conv_done_i(conv_done_i),
        .hi_wr_i(hi_wr_i), .lo_wr_i(lo_wr_i), .lim_wdata_i(lim_wdata_i),
        .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i), .stat_rd_i(stat_rd_i),
        .alarm_pin_o(alarm_pin_o), .alarm_stat_o(alarm_stat_o), .hi_flag_o(hi_flag_o),
        .lo_flag_o(lo_flag_o), .hi_lim_o(hi_lim_o), .lo_lim_o(lo_lim_o),
        .stat_word_o(stat_word_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic conv(input logic [15:0] v);
        @(negedge clk); result_i = v; conv_done_i = 1'b1;
        @(negedge clk); conv_done_i = 1'b0;
    endtask

    task automatic ctrl(input logic [15:0] v);
        @(negedge clk); ctrl_wdata_i = v; ctrl_wr_i = 1'b1;
        @(negedge clk); ctrl_wr_i = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk); stat_rd_i = 1'b1;
        @(negedge clk); stat_rd_i = 1'b0;
    endtask

    task automatic wr_lim(input bit hi, input logic [15:0] v);
        @(negedge clk); lim_wdata_i = v; hi_wr_i = hi; lo_wr_i = !hi;
        @(negedge clk); hi_wr_i = 1'b0; lo_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 hi reset", hi_lim_o, 16'h4880);
        check("R10 lo reset", lo_lim_o, 16'h4600);
        check("R5 idle pin active-low", {15'd0, alarm_pin_o}, 16'd1);
        check("R7 reset status word", stat_word_o, 16'h0800);
    endtask

    task automatic t_trip();
        conv(16'h489F);
        check("R11 masked bits no trip", {15'd0, alarm_pin_o}, 16'd1);
        conv(16'h4880);
        check("R1 equal no trip", {15'd0, alarm_pin_o}, 16'd1);
        check("R8 equal no hi flag", {15'd0, hi_flag_o}, 16'd0);
        conv(16'h48A0);
        check("R1 above trips", {15'd0, alarm_pin_o}, 16'd0);
        check("R7 status follows pin", {15'd0, alarm_stat_o}, 16'd0);
        check("R8 hi flag set", {15'd0, hi_flag_o}, 16'd1);
        read_stat();
        check("R8 read while above keeps", {15'd0, hi_flag_o}, 16'd1);
    endtask

    task automatic t_release();
        conv(16'h4700);
        check("R2 between holds", {15'd0, alarm_pin_o}, 16'd0);
        check("R8 flag held before read", {15'd0, hi_flag_o}, 16'd1);
        read_stat();
        check("R8 read after drop clears", {15'd0, hi_flag_o}, 16'd0);
        conv(16'h4600);
        check("R2 equal low holds", {15'd0, alarm_pin_o}, 16'd0);
        conv(16'h45E0);
        check("R2 below releases", {15'd0, alarm_pin_o}, 16'd1);
        check("R9 lo flag set", {15'd0, lo_flag_o}, 16'd1);
        read_stat();
        check("R9 read while below keeps", {15'd0, lo_flag_o}, 16'd1);
        conv(16'h4600);
        check("R9 held before read", {15'd0, lo_flag_o}, 16'd1);
        read_stat();
        check("R9 read after recovery clears", {15'd0, lo_flag_o}, 16'd0);
    endtask

    task automatic t_clear();
        conv(16'h5000);
        check("R1 trip again", {15'd0, alarm_pin_o}, 16'd0);
        ctrl(16'h2000);
        check("R3 clear drops alarm", {15'd0, alarm_pin_o}, 16'd1);
        check("R3 clear bit reads 0", stat_word_o, 16'h0C00);
        conv(16'h5000);
        check("R3 re-arms on next conversion", {15'd0, alarm_pin_o}, 16'd0);
        ctrl(16'hC000);
        check("R4 shutdown/one-shot keep alarm", {15'd0, alarm_pin_o}, 16'd0);
    endtask

    task automatic t_pol_dis();
        ctrl(16'h0040);
        check("R5 active-high pin", {15'd0, alarm_pin_o}, 16'd1);
        check("R7 status word pol", stat_word_o, 16'h0C40);
        ctrl(16'h00C0);
        check("R6 disable forces inactive", {15'd0, alarm_pin_o}, 16'd0);
        ctrl(16'h0040);
        check("R6 state kept through disable", {15'd0, alarm_pin_o}, 16'd1);
    endtask

    task automatic t_limits();
        wr_lim(1'b0, 16'hFFFF);
        check("R10 lo low bits zero", lo_lim_o, 16'hFFE0);
        conv(16'hF000);
        check("R2 signed below releases", {15'd0, alarm_pin_o}, 16'd0);
        wr_lim(1'b1, 16'hE01F);
        check("R10 hi low bits zero", hi_lim_o, 16'hE000);
        check("R11 limit write no effect", {15'd0, alarm_pin_o}, 16'd0);
        conv(16'h0100);
        check("R1 signed compare trips", {15'd0, alarm_pin_o}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trip();
        t_release();
        t_clear();
        t_pol_dis();
        t_limits();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule